// File: doc/BRIEF.md
# Scatter-Gather Chain Walker

This block follows the list of data-chain entries stored in one command block in word memory and turns each entry into a transfer request for a data mover. Every entry occupies two consecutive 32-bit words: a count word and then a transfer address. Bit 31 of the count word says whether another entry follows. Bits 30:0 give the transfer length in 32-bit words. The walker reads one entry, checks it, hands it to the data mover and then either moves to the next entry or finishes.

A controller pulses `start` with the byte address of the first entry. Entry n is then read from that address plus 8·n, with its count word at +0 and its address word at +4. Both outgoing streams use valid/ready. A read request or a transfer request, once raised, keeps its payload unchanged and stays raised until the receiver accepts it with ready, so the receiver can apply back-pressure for as long as it needs to. Read data returns on a plain `rsp_valid` strobe. Only one read is outstanding at any time, so the response always belongs to the last accepted request.

The walk has hard limits. An entry longer than `MAX_WORDS` words aborts the walk, and so does a chain that still asks for more after `MAX_ENTRIES` entries. Either case raises `chain_err`, and `err_oversize` tells the two causes apart. A chain that ends normally gives a one-cycle `done`.

Top module: `sg_chain_walker`

## Requirements
- R1: A `start` accepted while idle reads entry n from byte address `start_addr + 8*n`: the count word at that address and the address word at that address plus 4, in that order.
- R2: A transfer request carries the entry's address word on `xfer_addr` and bits 30:0 of its count word on `xfer_words`. Bit 31 of the count word set means another entry follows.
- R3: While `xfer_valid` is high and `xfer_ready` is low, the request stays high with `xfer_addr` and `xfer_words` unchanged.
- R4: An entry with a word count of zero issues no transfer request, and the walk continues according to its continue bit.
- R5: An entry whose count is above `MAX_WORDS` (16384) issues no transfer. The walk ends with `chain_err` high for one cycle and `err_oversize` = 1. A count of exactly 16384 is transferred.
- R6: If entry index `MAX_ENTRIES-1` (the 33rd entry) has its continue bit set, no transfer is issued for it and no further entry is read. The walk ends with `chain_err` high for one cycle and `err_oversize` = 0. This check takes priority over the count check.
- R7: `done` is high for exactly one cycle, in the cycle after the last entry completes (its transfer is accepted, or it has a zero count), and `busy` is low in that cycle. `done` and `chain_err` are never high together.
- R8: `start` is ignored while `busy` is high.
- R9: While `rd_valid` is high and `rd_ready` is low, the read request stays high with `rd_addr` unchanged.
- R10: After reset `busy`, `rd_valid`, `xfer_valid`, `done` and `chain_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (accepted only while idle) |
| start_addr | input | ADDR_W | Byte address of the first chain entry |
| busy | output | 1 | A walk is in progress |
| rd_valid | output | 1 | Word read request valid |
| rd_ready | input | 1 | Memory accepts the read request |
| rd_addr | output | ADDR_W | Byte address of the word to read |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Read data word |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Data mover accepts the transfer request |
| xfer_addr | output | 32 | Transfer address from the entry |
| xfer_words | output | WORDS_W | Transfer length in 32-bit words |
| done | output | 1 | One-cycle pulse: chain completed |
| chain_err | output | 1 | One-cycle pulse: walk aborted |
| err_oversize | output | 1 | With `chain_err`: 1 = entry too long, 0 = chain too long |

## Verification
The assertions check on every cycle that held read and transfer requests keep their payload, that no transfer is ever requested with a zero or over-limit length, that the entry index stays within the chain limit, and that `done` is a single cycle and never coincides with `chain_err`. The bench scenarios cover the rest. They check the exact sequence of read addresses and transfers for each chain, that a zero-count entry is skipped, that the walk stops at the right entry with the right error cause, that exactly 16384 words is accepted, and that a `start` arriving mid-walk leaves the walk unchanged. These scenarios use random back-pressure and read latency.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    W_IDLE,
    W_LAUNCH,
    W_FETCH,
    W_EVAL,
    W_XFER
  } walk_state_t;

  typedef enum logic [1:0] {
    F_IDLE,
    F_REQ,
    F_WAIT
  } fetch_state_t;

  typedef struct packed {
    logic        more;
    logic [30:0] words;
    logic [31:0] addr;
  } chain_ent_t;
endpackage

// File: rtl/sgw_cursor.sv
module sgw_cursor #(
  parameter int ADDR_W      = 32,
  parameter int MAX_ENTRIES = 33,
  parameter int IDX_W       = $clog2(MAX_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              advance,
  output logic [ADDR_W-1:0] entry_addr,
  output logic              at_last
);
  localparam int ENT_BYTES_LOG2 = 3;

  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      base_q <= base;
      idx_q  <= '0;
    end else if (advance) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign entry_addr = base_q + (ADDR_W'(idx_q) << ENT_BYTES_LOG2);
  assign at_last    = (idx_q == IDX_W'(MAX_ENTRIES - 1));

  a_r6_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(MAX_ENTRIES - 1));
  a_r6_no_step_past_last: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |-> !at_last);
endmodule

// File: rtl/sgw_fetch.sv
module sgw_fetch
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] entry_addr,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              ent_valid,
  output chain_ent_t        ent
);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

  fetch_state_t      st_q;
  logic              second_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= F_IDLE;
      second_q  <= 1'b0;
      addr_q    <= '0;
      ent_valid <= 1'b0;
      ent       <= '0;
    end else begin
      ent_valid <= 1'b0;
      case (st_q)
        F_IDLE: begin
          if (go) begin
            st_q     <= F_REQ;
            second_q <= 1'b0;
            addr_q   <= entry_addr;
          end
        end
        F_REQ: begin
          if (rd_ready) st_q <= F_WAIT;
        end
        F_WAIT: begin
          if (rsp_valid) begin
            if (!second_q) begin
              ent.more  <= rsp_data[WORD_W-1];
              ent.words <= rsp_data[WORD_W-2:0];
              second_q  <= 1'b1;
              addr_q    <= addr_q + WORD_BYTES;
              st_q      <= F_REQ;
            end else begin
              ent.addr  <= rsp_data;
              ent_valid <= 1'b1;
              st_q      <= F_IDLE;
            end
          end
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  assign rd_valid = (st_q == F_REQ);
  assign rd_addr  = addr_q;

  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
  a_r1_no_go_while_active: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (st_q == F_IDLE));
endmodule

// File: rtl/sgw_xfer.sv
module sgw_xfer #(
  parameter int MAX_WORDS = 16384,
  parameter int WORDS_W   = $clog2(MAX_WORDS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [31:0]        l_addr,
  input  logic [30:0]        l_words,
  output logic               xfer_valid,
  input  logic               xfer_ready,
  output logic [31:0]        xfer_addr,
  output logic [WORDS_W-1:0] xfer_words,
  output logic               fire
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_valid <= 1'b0;
      xfer_addr  <= '0;
      xfer_words <= '0;
    end else if (load) begin
      xfer_valid <= 1'b1;
      xfer_addr  <= l_addr;
      xfer_words <= WORDS_W'(l_words);
    end else if (fire) begin
      xfer_valid <= 1'b0;
    end
  end

  assign fire = xfer_valid && xfer_ready;

  a_r3_xfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=>
      (xfer_valid && $stable(xfer_addr) && $stable(xfer_words)));
  a_r4_no_zero_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (xfer_words != '0));
  a_r5_len_limit: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (xfer_words <= WORDS_W'(MAX_WORDS)));
  a_r3_no_reload_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !xfer_valid);
endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
  import sgw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MAX_ENTRIES = 33,
  parameter int MAX_WORDS   = 16384,
  parameter int WORDS_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  start_addr,
  output logic               busy,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic               rsp_valid,
  input  logic [31:0]        rsp_data,
  output logic               xfer_valid,
  input  logic               xfer_ready,
  output logic [31:0]        xfer_addr,
  output logic [WORDS_W-1:0] xfer_words,
  output logic               done,
  output logic               chain_err,
  output logic               err_oversize
);
  localparam logic [30:0] WORD_LIMIT = 31'(MAX_WORDS);

  walk_state_t       st_q, st_d;
  logic              cur_load, cur_advance, at_last;
  logic [ADDR_W-1:0] entry_addr;
  logic              fetch_go, ent_valid;
  chain_ent_t        ent;
  logic              xf_load, xf_fire;
  logic              fin_ok, fin_long, fin_over;

  sgw_cursor #(.ADDR_W(ADDR_W), .MAX_ENTRIES(MAX_ENTRIES)) u_cursor (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cur_load),
    .base       (start_addr),
    .advance    (cur_advance),
    .entry_addr (entry_addr),
    .at_last    (at_last)
  );

  sgw_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (fetch_go),
    .entry_addr (entry_addr),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_addr    (rd_addr),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .ent_valid  (ent_valid),
    .ent        (ent)
  );

  sgw_xfer #(.MAX_WORDS(MAX_WORDS), .WORDS_W(WORDS_W)) u_xfer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (xf_load),
    .l_addr     (ent.addr),
    .l_words    (ent.words),
    .xfer_valid (xfer_valid),
    .xfer_ready (xfer_ready),
    .xfer_addr  (xfer_addr),
    .xfer_words (xfer_words),
    .fire       (xf_fire)
  );

  // Next-state and strobe decode.
  always_comb begin
    st_d        = st_q;
    cur_load    = 1'b0;
    cur_advance = 1'b0;
    fetch_go    = 1'b0;
    xf_load     = 1'b0;
    fin_ok      = 1'b0;
    fin_long    = 1'b0;
    fin_over    = 1'b0;
    case (st_q)
      W_IDLE: begin
        if (start) begin
          cur_load = 1'b1;
          st_d     = W_LAUNCH;
        end
      end
      W_LAUNCH: begin
        fetch_go = 1'b1;
        st_d     = W_FETCH;
      end
      W_FETCH: begin
        if (ent_valid) st_d = W_EVAL;
      end
      W_EVAL: begin
        if (ent.more && at_last) begin
          fin_long = 1'b1;
          st_d     = W_IDLE;
        end else if (ent.words > WORD_LIMIT) begin
          fin_over = 1'b1;
          st_d     = W_IDLE;
        end else if (ent.words == '0) begin
          if (ent.more) begin
            cur_advance = 1'b1;
            st_d        = W_LAUNCH;
          end else begin
            fin_ok = 1'b1;
            st_d   = W_IDLE;
          end
        end else begin
          xf_load = 1'b1;
          st_d    = W_XFER;
        end
      end
      W_XFER: begin
        if (xf_fire) begin
          if (ent.more) begin
            cur_advance = 1'b1;
            st_d        = W_LAUNCH;
          end else begin
            fin_ok = 1'b1;
            st_d   = W_IDLE;
          end
        end
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= W_IDLE;
      done         <= 1'b0;
      chain_err    <= 1'b0;
      err_oversize <= 1'b0;
    end else begin
      st_q      <= st_d;
      done      <= fin_ok;
      chain_err <= fin_long || fin_over;
      if (cur_load)      err_oversize <= 1'b0;
      else if (fin_over) err_oversize <= 1'b1;
    end
  end

  assign busy = (st_q != W_IDLE);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && chain_err));
  a_r7_idle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done || chain_err) |-> !busy);
  a_r6_no_read_after_err: assert property (@(posedge clk) disable iff (!rst_n)
    chain_err |-> !rd_valid);
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done || chain_err));
endmodule

// File: tb/sim_sg_chain_walker.sv
module sim_sg_chain_walker;
  localparam int MEMW = 1024;
  localparam int MAXE = 33;
  localparam int MAXW = 16384;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic        busy, rd_valid, rd_ready, rsp_valid;
  logic [31:0] rd_addr, rsp_data, xfer_addr;
  logic        xfer_valid, xfer_ready, done, chain_err, err_oversize;
  logic [14:0] xfer_words;

  always #4 clk = ~clk;

  sg_chain_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .busy(busy), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_addr(xfer_addr), .xfer_words(xfer_words),
    .done(done), .chain_err(chain_err), .err_oversize(err_oversize)
  );

  int total = 0, bad = 0;
  logic [31:0] mem [MEMW];

  // Expected results
  int          exp_kind;            // 0 done, 1 too long, 2 oversize
  int          exp_nx, exp_nent;
  logic [31:0] exp_xa [40];
  int          exp_xw [40];
  // Observed results
  int          obs_nx, obs_nrd, obs_done, obs_err, obs_wide;
  logic        obs_over, prev_done;
  logic [31:0] obs_xa [40];
  int          obs_xw [40];
  logic [31:0] obs_rd [80];
  // Memory model state
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;
  int          pend_dly = 0;
  int          ready_mode = 0;      // 0 random, 1 always ready

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Input driving, just after each rising edge.
  always @(posedge clk) begin
    #1;
    rd_ready   = (ready_mode == 1) ? 1'b1 : (($urandom % 4) != 0);
    xfer_ready = (ready_mode == 1) ? 1'b1 : (($urandom % 3) != 0);
    rsp_valid  = 1'b0;
    if (pend) begin
      if (pend_dly == 0) begin
        rsp_valid = 1'b1;
        rsp_data  = mem[pend_addr[11:2]];
        pend      = 1'b0;
      end else begin
        pend_dly--;
      end
    end
  end

  // Monitor, mid-cycle: a handshake seen here completes at the next edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid && rd_ready) begin
        if (obs_nrd < 80) obs_rd[obs_nrd] = rd_addr;
        obs_nrd++;
        pend      = 1'b1;
        pend_addr = rd_addr;
        pend_dly  = (ready_mode == 1) ? 0 : int'($urandom % 3);
      end
      if (xfer_valid && xfer_ready) begin
        if (obs_nx < 40) begin
          obs_xa[obs_nx] = xfer_addr;
          obs_xw[obs_nx] = int'(xfer_words);
        end
        obs_nx++;
      end
      if (done) obs_done++;
      if (done && prev_done) obs_wide++;
      prev_done = done;
      if (chain_err) begin
        obs_err++;
        obs_over = err_oversize;
      end
    end
  end

  // Reference walk computed from the requirements.
  task automatic predict(input logic [31:0] base, input int n);
    exp_nx = 0; exp_kind = 0; exp_nent = 0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] cw, aw;
      cw = mem[(base >> 2) + 2 * i];
      aw = mem[(base >> 2) + 2 * i + 1];
      exp_nent = i + 1;
      if (cw[31] && i == MAXE - 1) begin exp_kind = 1; break; end
      if (cw[30:0] > MAXW) begin exp_kind = 2; break; end
      if (cw[30:0] != 0) begin
        exp_xa[exp_nx] = aw;
        exp_xw[exp_nx] = int'(cw[30:0]);
        exp_nx++;
      end
      if (!cw[31]) break;
    end
  endtask

  task automatic run(input logic [31:0] base, input int n, input bit poke);
    int guard;
    predict(base, n);
    obs_nx = 0; obs_nrd = 0; obs_done = 0; obs_err = 0; obs_wide = 0;
    obs_over = 1'b0; prev_done = 1'b0;
    @(posedge clk); #1;
    start_addr = base; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    guard = 0;
    while (obs_done + obs_err == 0 && guard < 5000) begin
      @(posedge clk); #1;
      guard++;
      if (poke && guard == 7) begin
        start_addr = base + 32'h100; start = 1'b1;   // R8 stimulus
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(guard < 5000, "R7", "walk finished", guard, 0);
    check(obs_done == (exp_kind == 0 ? 1 : 0), "R7", "done pulses", obs_done, exp_kind == 0);
    check(obs_wide == 0, "R7", "done width", obs_wide, 0);
    check(obs_err == (exp_kind == 0 ? 0 : 1), "R6", "chain_err pulses", obs_err, exp_kind != 0);
    if (exp_kind != 0)
      check(obs_over == (exp_kind == 2), "R5", "error cause", obs_over, exp_kind == 2);
    check(!busy, "R7", "busy after end", busy, 0);
    check(obs_nx == exp_nx, "R4", "transfer count", obs_nx, exp_nx);
    for (int i = 0; i < exp_nx && i < obs_nx; i++) begin
      check(obs_xa[i] == exp_xa[i], "R2", "transfer address", obs_xa[i], exp_xa[i]);
      check(obs_xw[i] == exp_xw[i], "R2", "transfer words", obs_xw[i], exp_xw[i]);
    end
    check(obs_nrd == 2 * exp_nent, "R1", "read count", obs_nrd, 2 * exp_nent);
    for (int i = 0; i < obs_nrd && i < 2 * exp_nent; i++)
      check(obs_rd[i] == base + 32'(4 * i), "R1", "read address", obs_rd[i], base + 32'(4 * i));
  endtask

  task automatic put(input logic [31:0] base, input int i, input bit more,
                     input logic [30:0] cnt);
    mem[(base >> 2) + 2 * i]     = {more, cnt};
    mem[(base >> 2) + 2 * i + 1] = $urandom;
  endtask

  function automatic logic [30:0] rand_cnt();
    int r;
    r = int'($urandom % 12);
    case (r)
      0: return 31'd0;
      1: return 31'(MAXW);
      2: return 31'(MAXW + 1 + int'($urandom % 500));
      default: return 31'(1 + ($urandom % 3000));
    endcase
  endfunction

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] b;
    void'($urandom(32'd20240611));
    for (int i = 0; i < MEMW; i++) mem[i] = '0;
    rd_ready = 1'b0; xfer_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !rd_valid && !xfer_valid && !done && !chain_err, "R10",
          "reset outputs", {busy, rd_valid, xfer_valid, done, chain_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !rd_valid && !xfer_valid, "R10", "idle after reset",
          {busy, rd_valid, xfer_valid}, 0);

    // R2/R3: single entry under back-pressure
    b = 32'h40; put(b, 0, 1'b0, 31'd5); run(b, 1, 1'b0);
    // R4: zero-count entries in the middle and at the end
    b = 32'h200; put(b, 0, 1'b1, 31'd0); put(b, 1, 1'b1, 31'd9); put(b, 2, 1'b0, 31'd0);
    run(b, 3, 1'b0);
    // R5: exact limit accepted, one above rejected
    b = 32'h300; put(b, 0, 1'b1, 31'(MAXW)); put(b, 1, 1'b1, 31'(MAXW + 1));
    put(b, 2, 1'b0, 31'd4); run(b, 3, 1'b0);
    // R6: 33 entries ending normally
    b = 32'h800;
    for (int i = 0; i < MAXE; i++) put(b, i, i != MAXE - 1, 31'(1 + i));
    run(b, MAXE, 1'b0);
    // R6: continue bit still set on entry 33, even with oversize count there
    b = 32'h800;
    for (int i = 0; i < MAXE + 1; i++) put(b, i, 1'b1, 31'(i == MAXE - 1 ? MAXW + 7 : 2));
    run(b, MAXE + 1, 1'b0);
    // R8: start pulsed mid-walk
    b = 32'hA00;
    for (int i = 0; i < 4; i++) put(b, i, i != 3, 31'(10 * (i + 1)));
    run(b, 4, 1'b1);
    // R7: zero-latency memory and always-ready mover
    ready_mode = 1;
    b = 32'h60; put(b, 0, 1'b1, 31'd3); put(b, 1, 1'b0, 31'd8); run(b, 2, 1'b0);
    ready_mode = 0;

    // Constrained random chains (R1 R2 R3 R4 R5 R9)
    for (int t = 0; t < 40; t++) begin
      int n;
      n = 1 + int'($urandom % 8);
      b = 32'(($urandom % 900) * 4);
      for (int i = 0; i < n; i++) put(b, i, i != n - 1, rand_cnt());
      run(b, n, (t % 5) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule